// File: doc/BRIEF.md
# Legacy System Control Port Decoder

This block is the byte-wide I/O register set of a 286-class system board. It decodes a handful of fixed port addresses on a 16-bit I/O bus and keeps the control state behind them. From that state it drives several outputs: the alternate A20 gate, a CPU soft-reset pulse, the serial port enable, the parallel port enable with its base-address select, and two memory-bank enables. The bank enables are stored in an indexed register file that is reached through an index port and a data port. It also latches a hardware status byte that software reads and clears.

A strap input, `model_late`, picks between the early and the later board revision. The strap changes four things: how the reset-control port stores bit 0, whether a soft-reset pulse can be issued, which read-back bits are forced high, and whether the indexed file can be reached at all.

All port writes take effect on the clock edge that ends the cycle in which `io_wr` is high. Read data is combinational from the current address. The block carries no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `sysctl_port_decoder`

## Requirements
- R1: A write to port 0x0092 sets `a20_alt` to data bit 1, visible in the cycle after the write.
- R2: With `model_late`=1, a write to 0x0092 with bit 0 set makes `cpu_soft_reset` high for exactly one cycle, the cycle after the write, and 0x0092 then reads back with bit 0 clear.
- R3: With `model_late`=0, a write to 0x0092 stores the full byte, bit 0 included, and never raises `cpu_soft_reset`.
- R4: Port 0x0102 controls the serial and parallel ports. Bit 2 drives `serial_en`, and `lpt_base_sel` equals bits 6:5 (0 = 0x3BC, 1 = 0x378, 2 = 0x278). `lpt_en` is high when bit 4 is set and bits 6:5 are not 3.
- R5: With `model_late`=0, reads of 0x0102 return the stored byte with bit 3 forced to 1. With `model_late`=1, reads of 0x0105 return the stored byte with bit 7 forced to 1. In every other case the stored byte is returned unchanged.
- R6: Each cycle, bits high on `hw_status_in` are ORed into a status latch. A read of 0x0091 returns the latch and then clears it at the end of the read cycle. A bit that arrives in that same read cycle survives the clear.
- R7: With `model_late`=1, a write to 0x00E0 sets an 8-bit index, and 0x00E1 reads or writes entry [index] of a 256-entry byte file. Bit 0 of entry 0 drives `mem_lo512_en` and bit 0 of entry 1 drives `mem_512_640_en`. A read of 0x00E0 returns 0xFF.
- R8: With `model_late`=0, writes to 0x00E0 and 0x00E1 change neither the index nor the file, and reads of both ports return 0xFF.
- R9: Ports 0x0094, 0x0103, 0x0104 and 0x0190 are plain byte storage. A read of any address the block does not decode returns 0xFF.
- R10: After reset every register is zero, except port 0x0102, which holds 0x10. The parallel port therefore comes up enabled at base code 0, and all other outputs start low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| model_late | input | 1 | Board revision strap: 1 = later model, 0 = early model |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_rdata | output | 8 | Read data for the addressed port (combinational) |
| hw_status_in | input | 8 | Hardware status bits to latch |
| a20_alt | output | 1 | Alternate A20 gate |
| cpu_soft_reset | output | 1 | Single-cycle CPU soft-reset pulse |
| serial_en | output | 1 | Serial port enable |
| lpt_en | output | 1 | Parallel port enable |
| lpt_base_sel | output | 2 | Parallel port base select code |
| mem_lo512_en | output | 1 | Internal RAM enable for the first 512K |
| mem_512_640_en | output | 1 | Internal RAM enable for 512K to 640K |

## Verification
The outputs that follow a register (A20, the serial and parallel enables, the bank enables) change one clock after the write cycle. The bench drives every write on a falling edge and samples these outputs on the next falling edge, so each sample lands after the one register stage. The soft-reset pulse is checked on that same falling edge and again one cycle later, which confirms it lasts exactly one cycle. Read data is combinational, so it is sampled a quarter period after the address is applied, inside the read cycle. The status read-clear is then confirmed with a second read.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] PA_HWSTAT  = 16'h0091;
  localparam logic [ADDR_W-1:0] PA_RSTA20  = 16'h0092;
  localparam logic [ADDR_W-1:0] PA_SCR_A   = 16'h0094;
  localparam logic [ADDR_W-1:0] PA_INDEX   = 16'h00E0;
  localparam logic [ADDR_W-1:0] PA_DATA    = 16'h00E1;
  localparam logic [ADDR_W-1:0] PA_PERCFG  = 16'h0102;
  localparam logic [ADDR_W-1:0] PA_SCR_B   = 16'h0103;
  localparam logic [ADDR_W-1:0] PA_SCR_C   = 16'h0104;
  localparam logic [ADDR_W-1:0] PA_BOOTCFG = 16'h0105;
  localparam logic [ADDR_W-1:0] PA_SCR_D   = 16'h0190;

  localparam logic [DATA_W-1:0] PERCFG_RST = 8'h10;
  localparam logic [DATA_W-1:0] OPEN_BUS   = 8'hFF;

  typedef struct packed {
    logic hwstat;
    logic rsta20;
    logic scr_a;
    logic index;
    logic data;
    logic percfg;
    logic scr_b;
    logic scr_c;
    logic bootcfg;
    logic scr_d;
  } port_sel_t;
endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
  import sysctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              model_late,
  output port_sel_t         sel
);
  always_comb begin
    sel         = '0;
    sel.hwstat  = (addr == PA_HWSTAT);
    sel.rsta20  = (addr == PA_RSTA20);
    sel.scr_a   = (addr == PA_SCR_A);
    sel.index   = (addr == PA_INDEX) && model_late;
    sel.data    = (addr == PA_DATA) && model_late;
    sel.percfg  = (addr == PA_PERCFG);
    sel.scr_b   = (addr == PA_SCR_B);
    sel.scr_c   = (addr == PA_SCR_C);
    sel.bootcfg = (addr == PA_BOOTCFG);
    sel.scr_d   = (addr == PA_SCR_D);
  end
endmodule

// File: rtl/sysctl_core_regs.sv
module sysctl_core_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned N_SCRATCH = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              model_late,
  input  port_sel_t         sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_status_in,
  output logic [DATA_W-1:0] rdata,
  output logic              a20_alt,
  output logic              cpu_soft_reset,
  output logic              serial_en,
  output logic              lpt_en,
  output logic [1:0]        lpt_base_sel
);
  logic [DATA_W-1:0] rsta20_q, percfg_q, bootcfg_q, status_q;
  logic              soft_rst_q;
  logic              wr_rsta20;
  logic [N_SCRATCH-1:0] scr_sel;
  logic [DATA_W-1:0] scr_q [N_SCRATCH];

  assign wr_rsta20 = wr && sel.rsta20;
  assign scr_sel   = {sel.scr_d, sel.scr_c, sel.scr_b, sel.scr_a};

  // Reset/A20 control: later model drops bit 0 and turns it into a pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsta20_q   <= '0;
      soft_rst_q <= 1'b0;
    end else begin
      if (wr_rsta20)
        rsta20_q <= model_late ? {wdata[DATA_W-1:1], 1'b0} : wdata;
      soft_rst_q <= wr_rsta20 && model_late && wdata[0] && !soft_rst_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      percfg_q  <= PERCFG_RST;
      bootcfg_q <= '0;
    end else begin
      if (wr && sel.percfg)  percfg_q  <= wdata;
      if (wr && sel.bootcfg) bootcfg_q <= wdata;
    end
  end

  // Hardware status: read clears, new arrivals in the same cycle survive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= ((rd && sel.hwstat) ? '0 : status_q) | hw_status_in;
  end

  for (genvar g = 0; g < N_SCRATCH; g++) begin : g_scratch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 scr_q[g] <= '0;
      else if (wr && scr_sel[g])  scr_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = OPEN_BUS;
    if (sel.hwstat)       rdata = status_q;
    else if (sel.rsta20)  rdata = rsta20_q;
    else if (sel.percfg)  rdata = model_late ? percfg_q : (percfg_q | 8'h08);
    else if (sel.bootcfg) rdata = model_late ? (bootcfg_q | 8'h80) : bootcfg_q;
    else begin
      for (int i = 0; i < N_SCRATCH; i++)
        if (scr_sel[i]) rdata = scr_q[i];
    end
  end

  assign a20_alt        = rsta20_q[1];
  assign cpu_soft_reset = soft_rst_q;
  assign serial_en      = percfg_q[2];
  assign lpt_base_sel   = percfg_q[6:5];
  assign lpt_en         = percfg_q[4] && (percfg_q[6:5] != 2'b11);

  AST_A20_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rsta20 |=> a20_alt == $past(wdata[1])); // R1
  AST_SOFT_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_soft_reset |=> !cpu_soft_reset); // R2
  AST_SOFT_RESET_LATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_soft_reset |-> $past(model_late)); // R3
  AST_SERIAL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel.percfg) |=> serial_en == $past(wdata[2])); // R4
  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel.hwstat && hw_status_in == '0) |=> status_q == '0); // R6
endmodule

// File: rtl/sysctl_idx_file.sv
module sysctl_idx_file
  import sysctl_pkg::*;
#(
  parameter int unsigned DEPTH = 256
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_index,
  input  logic              sel_data,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              bank_lo_en,
  output logic              bank_hi_en
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] file_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx_q <= '0;
    else if (wr && sel_index)  idx_q <= wdata[IDX_W-1:0];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     file_q[g] <= '0;
      else if (wr && sel_data && idx_q == IDX_W'(g))  file_q[g] <= wdata;
    end
  end

  assign rdata      = sel_data ? file_q[idx_q] : OPEN_BUS;
  assign bank_lo_en = file_q[0][0];
  assign bank_hi_en = file_q[1][0];

  AST_BANK_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_data && idx_q == '0) |=> bank_lo_en == $past(wdata[0])); // R7
endmodule

// File: rtl/sysctl_port_decoder.sv
module sysctl_port_decoder
  import sysctl_pkg::*;
#(
  parameter int unsigned IDX_DEPTH = 256,
  parameter int unsigned N_SCRATCH = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        model_late,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        io_wr,
  input  logic        io_rd,
  output logic [7:0]  io_rdata,
  input  logic [7:0]  hw_status_in,
  output logic        a20_alt,
  output logic        cpu_soft_reset,
  output logic        serial_en,
  output logic        lpt_en,
  output logic [1:0]  lpt_base_sel,
  output logic        mem_lo512_en,
  output logic        mem_512_640_en
);
  port_sel_t         sel;
  logic [DATA_W-1:0] core_rdata, idx_rdata;

  sysctl_addr_decode u_dec (
    .addr       (io_addr),
    .model_late (model_late),
    .sel        (sel)
  );

  sysctl_core_regs #(.N_SCRATCH(N_SCRATCH)) u_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .model_late     (model_late),
    .sel            (sel),
    .wr             (io_wr),
    .rd             (io_rd),
    .wdata          (io_wdata),
    .hw_status_in   (hw_status_in),
    .rdata          (core_rdata),
    .a20_alt        (a20_alt),
    .cpu_soft_reset (cpu_soft_reset),
    .serial_en      (serial_en),
    .lpt_en         (lpt_en),
    .lpt_base_sel   (lpt_base_sel)
  );

  sysctl_idx_file #(.DEPTH(IDX_DEPTH)) u_idx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_index  (sel.index),
    .sel_data   (sel.data),
    .wr         (io_wr),
    .wdata      (io_wdata),
    .rdata      (idx_rdata),
    .bank_lo_en (mem_lo512_en),
    .bank_hi_en (mem_512_640_en)
  );

  assign io_rdata = sel.data ? idx_rdata : core_rdata;

  AST_EARLY_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !model_late && (io_addr == PA_DATA || io_addr == PA_INDEX))
      |=> $stable({mem_lo512_en, mem_512_640_en})); // R8
endmodule

// File: tb/tb_sysctl_port_decoder.sv
module tb_sysctl_port_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        model_late = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [7:0]  hw_status_in = '0;
  logic        a20_alt, cpu_soft_reset, serial_en, lpt_en;
  logic [1:0]  lpt_base_sel;
  logic        mem_lo512_en, mem_512_640_en;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  sysctl_port_decoder dut (
    .clk(clk), .rst_n(rst_n), .model_late(model_late),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .hw_status_in(hw_status_in),
    .a20_alt(a20_alt), .cpu_soft_reset(cpu_soft_reset),
    .serial_en(serial_en), .lpt_en(lpt_en), .lpt_base_sel(lpt_base_sel),
    .mem_lo512_en(mem_lo512_en), .mem_512_640_en(mem_512_640_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic rd_port(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #5 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    check("R10 a20", {7'd0, a20_alt}, 8'h00);
    check("R10 soft reset", {7'd0, cpu_soft_reset}, 8'h00);
    check("R10 serial", {7'd0, serial_en}, 8'h00);
    check("R10 lpt_en", {7'd0, lpt_en}, 8'h01);
    check("R10 lpt_base", {6'd0, lpt_base_sel}, 8'h00);
    check("R10 banks", {6'd0, mem_512_640_en, mem_lo512_en}, 8'h00);
    rd_port(16'h0102, d); check("R10 0x102", d, 8'h10);
    rd_port(16'h0094, d); check("R10 0x94", d, 8'h00);
  endtask

  task automatic t_a20_softreset_late();
    logic [7:0] d;
    model_late = 1'b1;
    wr_port(16'h0092, 8'h03);
    check("R1 a20 set", {7'd0, a20_alt}, 8'h01);
    check("R2 pulse high", {7'd0, cpu_soft_reset}, 8'h01);
    @(negedge clk);
    check("R2 pulse one cycle", {7'd0, cpu_soft_reset}, 8'h00);
    rd_port(16'h0092, d); check("R2 bit0 cleared", d, 8'h02);
    wr_port(16'h0092, 8'h00);
    check("R1 a20 clear", {7'd0, a20_alt}, 8'h00);
  endtask

  task automatic t_softreset_early();
    logic [7:0] d;
    model_late = 1'b0;
    wr_port(16'h0092, 8'h03);
    check("R3 no pulse", {7'd0, cpu_soft_reset}, 8'h00);
    @(negedge clk);
    check("R3 no pulse later", {7'd0, cpu_soft_reset}, 8'h00);
    rd_port(16'h0092, d); check("R3 full byte", d, 8'h03);
    check("R1 a20 early", {7'd0, a20_alt}, 8'h01);
    wr_port(16'h0092, 8'h00);
    model_late = 1'b1;
  endtask

  task automatic t_peripheral_cfg();
    wr_port(16'h0102, 8'h34);
    check("R4 serial on", {7'd0, serial_en}, 8'h01);
    check("R4 lpt on code1", {5'd0, lpt_en, lpt_base_sel}, 8'h05);
    wr_port(16'h0102, 8'h50);
    check("R4 serial off", {7'd0, serial_en}, 8'h00);
    check("R4 lpt on code2", {5'd0, lpt_en, lpt_base_sel}, 8'h06);
    wr_port(16'h0102, 8'h70);
    check("R4 code3 disables", {5'd0, lpt_en, lpt_base_sel}, 8'h03);
    wr_port(16'h0102, 8'h24);
    check("R4 bit4 clear", {5'd0, lpt_en, lpt_base_sel}, 8'h01);
  endtask

  task automatic t_readback_force();
    logic [7:0] d;
    wr_port(16'h0102, 8'h70);
    wr_port(16'h0105, 8'h01);
    model_late = 1'b0;
    rd_port(16'h0102, d); check("R5 early 0x102 bit3", d, 8'h78);
    rd_port(16'h0105, d); check("R5 early 0x105 plain", d, 8'h01);
    model_late = 1'b1;
    rd_port(16'h0102, d); check("R5 late 0x102 plain", d, 8'h70);
    rd_port(16'h0105, d); check("R5 late 0x105 bit7", d, 8'h81);
  endtask

  task automatic t_status();
    logic [7:0] d;
    @(negedge clk); hw_status_in = 8'h05;
    @(negedge clk); hw_status_in = 8'h00;
    @(negedge clk); hw_status_in = 8'h02;
    @(negedge clk); hw_status_in = 8'h00;
    rd_port(16'h0091, d); check("R6 accumulated", d, 8'h07);
    rd_port(16'h0091, d); check("R6 cleared", d, 8'h00);
    @(negedge clk); hw_status_in = 8'h02;
    @(negedge clk); hw_status_in = 8'h00;
    @(negedge clk);
    io_addr = 16'h0091; io_rd = 1'b1; hw_status_in = 8'h40;
    #5 d = io_rdata;
    check("R6 read during arrival", d, 8'h02);
    @(negedge clk);
    io_rd = 1'b0; io_addr = 16'h0000; hw_status_in = 8'h00;
    rd_port(16'h0091, d); check("R6 arrival survives clear", d, 8'h40);
  endtask

  task automatic t_idx_late();
    logic [7:0] d;
    model_late = 1'b1;
    wr_port(16'h00E0, 8'h00); wr_port(16'h00E1, 8'h01);
    check("R7 lo bank on", {6'd0, mem_512_640_en, mem_lo512_en}, 8'h01);
    wr_port(16'h00E0, 8'h01); wr_port(16'h00E1, 8'hFF);
    check("R7 both banks on", {6'd0, mem_512_640_en, mem_lo512_en}, 8'h03);
    wr_port(16'h00E0, 8'h80); wr_port(16'h00E1, 8'h5A);
    rd_port(16'h00E1, d); check("R7 entry 0x80", d, 8'h5A);
    wr_port(16'h00E0, 8'h00);
    rd_port(16'h00E1, d); check("R7 entry 0", d, 8'h01);
    rd_port(16'h00E0, d); check("R7 index read FF", d, 8'hFF);
  endtask

  task automatic t_idx_early();
    logic [7:0] d;
    model_late = 1'b0;
    wr_port(16'h00E0, 8'h01);
    wr_port(16'h00E1, 8'h00);
    check("R8 banks unchanged", {6'd0, mem_512_640_en, mem_lo512_en}, 8'h03);
    rd_port(16'h00E1, d); check("R8 data read FF", d, 8'hFF);
    rd_port(16'h00E0, d); check("R8 index read FF", d, 8'hFF);
    model_late = 1'b1;
    rd_port(16'h00E1, d); check("R8 index kept", d, 8'h01);
  endtask

  task automatic t_scratch();
    logic [7:0] d;
    wr_port(16'h0094, 8'hA5); wr_port(16'h0103, 8'h3C);
    wr_port(16'h0104, 8'hC3); wr_port(16'h0190, 8'h96);
    rd_port(16'h0094, d); check("R9 0x94", d, 8'hA5);
    rd_port(16'h0103, d); check("R9 0x103", d, 8'h3C);
    rd_port(16'h0104, d); check("R9 0x104", d, 8'hC3);
    rd_port(16'h0190, d); check("R9 0x190", d, 8'h96);
    rd_port(16'h0093, d); check("R9 unmapped 0x93", d, 8'hFF);
    rd_port(16'h1094, d); check("R9 unmapped 0x1094", d, 8'hFF);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_a20_softreset_late();
    t_softreset_early();
    t_peripheral_cfg();
    t_readback_force();
    t_status();
    t_idx_late();
    t_idx_early();
    t_scratch();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule